// File: doc/BRIEF.md
# Compressed Instruction Fetch Aligner

This block sits between the instruction fetch stage and decode in a core that mixes 16-bit compressed instructions with full 32-bit ones. Each fetch response delivers a fixed number of consecutive 16-bit parcels starting at a halfword address. The block cuts the parcels into instructions and presents up to two of them per cycle, in program order. Each output slot carries the instruction's PC, its raw bits, its size, a fault flag and a trap value.

A 32-bit instruction whose low half is the last parcel of a response is held inside the block. It is completed by the first parcel of the next accepted response. Instructions beyond the two that fit in a cycle go into a small local buffer. They are issued on later cycles ahead of anything newer. When the buffer holds fewer than two entries, the free slots are filled from the incoming response in the same cycle.

A redirect discards the held half-instruction and all buffered work. The fetch input is back-pressured whenever the buffer could not absorb the worst-case leftover of a full response. A fault on the second half of a straddling instruction reports the faulting parcel address as the trap value.

Top module: `fetch_aligner`

## Requirements
- R1: A parcel whose bits [1:0] equal 2'b11 starts a 32-bit instruction built as {following parcel, this parcel}. Any other parcel is a 16-bit instruction, presented zero-extended in bits [15:0] with the size flag low.
- R2: Each valid slot carries the address of its first parcel. This is the response PC plus twice the parcel index. Slot 1 is valid only when slot 0 is valid, and slot 0 always holds the older instruction.
- R3: At most two instructions leave per cycle. Instructions beyond that are kept and issued on following cycles, before any instruction from a later response.
- R4: When fewer than two instructions are buffered, the free slots are filled in the same cycle from the response accepted in that cycle.
- R5: When the last parcel of a response starts a 32-bit instruction, that parcel is held. The first parcel of the next accepted response completes it, and the result carries the held parcel's address.
- R6: While redirect is high, no slot is valid and no response is accepted. The held parcel and all buffered instructions are discarded, so the first parcel after a redirect is decoded as the start of an instruction.
- R7: An accepted response with its fault flag set and no held parcel yields exactly one slot. That slot has the fault flag set, and both its PC and its trap value equal the response PC. The response's parcels are dropped.
- R8: An accepted faulting response that arrives while a parcel is held yields one 32-bit faulting slot. Its PC is the held parcel's address and its trap value is the faulting response PC. The held parcel is dropped.
- R9: fr_ready is low whenever the buffered count plus PARCELS exceeds DEPTH + 2, and the buffered count never exceeds DEPTH.
- R10: After reset no slot is valid, nothing is held, and fr_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fr_valid | input | 1 | A fetch response is offered |
| fr_ready | output | 1 | The offered response is accepted this cycle |
| fr_pc | input | 32 | Address of parcel 0 of the response |
| fr_parcels | input | 16*PARCELS | Parcels, parcel 0 in bits [15:0] |
| fr_fault | input | 1 | The response fetch faulted |
| redirect | input | 1 | Flush held and buffered work |
| out_valid | output | 2 | Per-slot valid, slot 0 in bit 0 |
| out_pc | output | 64 | Slot PCs, slot 0 in the low word |
| out_bits | output | 64 | Slot raw instruction bits |
| out_is32 | output | 2 | Slot holds a 32-bit instruction |
| out_fault | output | 2 | Slot reports a fetch fault |
| out_tval | output | 64 | Slot trap value |

## Verification
On every cycle, the assertions check slot packing and the effect of a redirect on the outputs and on the held and buffered state. They also check the buffer bound, and that a back-pressured cycle always issues two buffered instructions. Finally, they check that the held-parcel flag is only set by an accepted response. Which instruction lands in which slot, with which PC, bits and trap value, can only be seen by the bench's scenarios. These are compared cycle by cycle against a queue-based model: long runs of compressed parcels that fill the buffer, straddles, redirects in the middle of a straddle, both kinds of fault, and mixed streams.

// File: rtl/cfa_pkg.sv
package cfa_pkg;
  localparam int unsigned PC_W     = 32;
  localparam int unsigned PARCEL_W = 16;
  localparam int unsigned INSN_W   = 32;

  typedef struct packed {
    logic [PC_W-1:0]   pc;
    logic [INSN_W-1:0] bits;
    logic              is32;
    logic              fault;
    logic [PC_W-1:0]   tval;
  } slot_t;

  function automatic logic opens_wide(input logic [PARCEL_W-1:0] p);
    return p[1:0] == 2'b11;
  endfunction

  function automatic logic [PC_W-1:0] parcel_addr(input logic [PC_W-1:0] base, input int idx);
    return base + PC_W'(2 * idx);
  endfunction
endpackage

// File: rtl/cfa_splitter.sv
module cfa_splitter
  import cfa_pkg::*;
#(
  parameter int unsigned PARCELS = 4,
  localparam int unsigned NEW_W  = $clog2(PARCELS + 1)
) (
  input  logic [PC_W-1:0]              fr_pc,
  input  logic [PARCELS*PARCEL_W-1:0]  fr_parcels,
  input  logic                         fr_fault,
  input  logic                         held_q,
  input  logic [PARCEL_W-1:0]          held_lo,
  input  logic [PC_W-1:0]              held_pc,
  output slot_t                        ins [PARCELS],
  output logic [NEW_W-1:0]             n_ins,
  output logic                         held_d,
  output logic [PARCEL_W-1:0]          held_lo_d,
  output logic [PC_W-1:0]              held_pc_d
);
  logic [PARCEL_W-1:0] par [PARCELS];

  for (genvar g = 0; g < PARCELS; g++) begin : g_par
    assign par[g] = fr_parcels[g*PARCEL_W +: PARCEL_W];
  end

  always_comb begin
    int  n;
    logic skip;
    n         = 0;
    skip      = 1'b0;
    held_d    = 1'b0;
    held_lo_d = '0;
    held_pc_d = '0;
    for (int k = 0; k < PARCELS; k++) ins[k] = '0;

    if (fr_fault) begin
      ins[0].pc    = held_q ? held_pc : fr_pc;
      ins[0].bits  = held_q ? {{(INSN_W-PARCEL_W){1'b0}}, held_lo} : '0;
      ins[0].is32  = held_q;
      ins[0].fault = 1'b1;
      ins[0].tval  = fr_pc;
      n = 1;
    end else begin
      if (held_q) begin
        ins[0].pc   = held_pc;
        ins[0].bits = {par[0], held_lo};
        ins[0].is32 = 1'b1;
        n    = 1;
        skip = 1'b1;
      end
      for (int i = 0; i < PARCELS; i++) begin
        if (skip) begin
          skip = 1'b0;
        end else if (opens_wide(par[i])) begin
          if (i == PARCELS - 1) begin
            held_d    = 1'b1;
            held_lo_d = par[i];
            held_pc_d = parcel_addr(fr_pc, i);
          end else begin
            ins[n].pc   = parcel_addr(fr_pc, i);
            ins[n].bits = {par[(i+1) % PARCELS], par[i]};
            ins[n].is32 = 1'b1;
            n    = n + 1;
            skip = 1'b1;
          end
        end else begin
          ins[n].pc   = parcel_addr(fr_pc, i);
          ins[n].bits = {{(INSN_W-PARCEL_W){1'b0}}, par[i]};
          n = n + 1;
        end
      end
    end
    n_ins = NEW_W'(n);
  end
endmodule

// File: rtl/cfa_slot_queue.sv
module cfa_slot_queue
  import cfa_pkg::*;
#(
  parameter int unsigned DEPTH   = 4,
  parameter int unsigned PARCELS = 4,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1),
  localparam int unsigned NEW_W  = $clog2(PARCELS + 1),
  localparam int unsigned TOT    = DEPTH + PARCELS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             take,
  input  slot_t            new_ins [PARCELS],
  input  logic [NEW_W-1:0] n_new,
  output slot_t            head [2],
  output logic [1:0]       head_live,
  output logic [CNT_W-1:0] cnt
);
  slot_t            buf_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  slot_t            merged [TOT];
  logic [TOT-1:0]   live;
  int               cnt_d;

  always_comb begin
    int n_eff;
    int total;
    n_eff = take ? int'(n_new) : 0;
    for (int k = 0; k < TOT; k++) begin
      merged[k] = '0;
      if (k < int'(cnt_q)) begin
        if (k < DEPTH) merged[k] = buf_q[k];
      end else if ((k - int'(cnt_q)) < PARCELS) begin
        merged[k] = new_ins[k - int'(cnt_q)];
      end
      live[k] = k < (int'(cnt_q) + n_eff);
    end
    total = int'(cnt_q) + n_eff;
    cnt_d = (total > 2) ? total - 2 : 0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      cnt_q <= '0;
      for (int j = 0; j < DEPTH; j++) buf_q[j] <= '0;
    end else begin
      cnt_q <= CNT_W'(cnt_d);
      for (int j = 0; j < DEPTH; j++) buf_q[j] <= merged[j+2];
    end
  end

  assign head[0]   = merged[0];
  assign head[1]   = merged[1];
  assign head_live = live[1:0];
  assign cnt       = cnt_q;
endmodule

// File: rtl/fetch_aligner.sv
module fetch_aligner
  import cfa_pkg::*;
#(
  parameter int unsigned PARCELS = 4,
  parameter int unsigned DEPTH   = 4,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1),
  localparam int unsigned NEW_W  = $clog2(PARCELS + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         fr_valid,
  output logic                         fr_ready,
  input  logic [PC_W-1:0]              fr_pc,
  input  logic [PARCELS*PARCEL_W-1:0]  fr_parcels,
  input  logic                         fr_fault,
  input  logic                         redirect,
  output logic [1:0]                   out_valid,
  output logic [2*PC_W-1:0]            out_pc,
  output logic [2*INSN_W-1:0]          out_bits,
  output logic [1:0]                   out_is32,
  output logic [1:0]                   out_fault,
  output logic [2*PC_W-1:0]            out_tval
);
  logic                held_q, held_d;
  logic [PARCEL_W-1:0] held_lo_q, held_lo_d;
  logic [PC_W-1:0]     held_pc_q, held_pc_d;
  slot_t               split_ins [PARCELS];
  logic [NEW_W-1:0]    split_n;
  slot_t               head [2];
  logic [1:0]          head_live;
  logic [CNT_W-1:0]    buf_cnt;
  logic                fire;
  logic                room_ok;

  assign room_ok  = (int'(buf_cnt) + PARCELS) <= (DEPTH + 2);
  assign fr_ready = !redirect && room_ok;
  assign fire     = fr_valid && fr_ready;

  cfa_splitter #(.PARCELS(PARCELS)) u_split (
    .fr_pc     (fr_pc),
    .fr_parcels(fr_parcels),
    .fr_fault  (fr_fault),
    .held_q    (held_q),
    .held_lo   (held_lo_q),
    .held_pc   (held_pc_q),
    .ins       (split_ins),
    .n_ins     (split_n),
    .held_d    (held_d),
    .held_lo_d (held_lo_d),
    .held_pc_d (held_pc_d)
  );

  cfa_slot_queue #(.DEPTH(DEPTH), .PARCELS(PARCELS)) u_queue (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (redirect),
    .take     (fire),
    .new_ins  (split_ins),
    .n_new    (split_n),
    .head     (head),
    .head_live(head_live),
    .cnt      (buf_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || redirect) begin
      held_q    <= 1'b0;
      held_lo_q <= '0;
      held_pc_q <= '0;
    end else if (fire) begin
      held_q    <= held_d;
      held_lo_q <= held_lo_d;
      held_pc_q <= held_pc_d;
    end
  end

  assign out_valid = head_live & {2{!redirect}};

  for (genvar s = 0; s < 2; s++) begin : g_slot
    assign out_pc[s*PC_W +: PC_W]       = head[s].pc;
    assign out_bits[s*INSN_W +: INSN_W] = head[s].bits;
    assign out_is32[s]                  = head[s].is32;
    assign out_fault[s]                 = head[s].fault;
    assign out_tval[s*PC_W +: PC_W]     = head[s].tval;
  end
endmodule

// File: rtl/cfa_checks.sv
module cfa_checks #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             redirect,
  input logic             fr_ready,
  input logic             fr_fault,
  input logic             fire,
  input logic             held_q,
  input logic [CNT_W-1:0] buf_cnt,
  input logic [1:0]       out_valid
);
  p_slot_packing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid[1] |-> out_valid[0]);

  p_buffer_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(buf_cnt) >= 2 && !redirect) |-> out_valid == 2'b11);

  p_held_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held_q) |-> $past(fire));

  p_redirect_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (out_valid == 2'b00 && !fr_ready));

  p_redirect_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> (buf_cnt == '0 && !held_q));

  p_fault_drops_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && held_q && fr_fault && !redirect) |=> !held_q);

  p_depth_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(buf_cnt) <= DEPTH);

  p_stall_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!fr_ready && !redirect) |-> out_valid == 2'b11);
endmodule

bind fetch_aligner cfa_checks #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_checks (
  .clk      (clk),
  .rst_n    (rst_n),
  .redirect (redirect),
  .fr_ready (fr_ready),
  .fr_fault (fr_fault),
  .fire     (fire),
  .held_q   (held_q),
  .buf_cnt  (buf_cnt),
  .out_valid(out_valid)
);

// File: tb/fetch_aligner_tb.sv
`timescale 1ns/100ps
module fetch_aligner_tb;
  localparam int P = 4;
  localparam int D = 4;

  typedef struct {
    logic [31:0] pc;
    logic [31:0] bits;
    logic        is32;
    logic        fault;
    logic [31:0] tval;
  } ref_t;

  logic            clk = 0;
  logic            rst_n = 0;
  logic            fr_valid = 0;
  logic            fr_ready;
  logic [31:0]     fr_pc = 0;
  logic [P*16-1:0] fr_parcels = 0;
  logic            fr_fault = 0;
  logic            redirect = 0;
  logic [1:0]      out_valid;
  logic [63:0]     out_pc, out_bits, out_tval;
  logic [1:0]      out_is32, out_fault;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  ref_t        mq[$];
  bit          m_held = 0;
  logic [15:0] m_lo   = 0;
  logic [31:0] m_hpc  = 0;
  logic [31:0] cur_pc = 32'h1000;

  always #2.5 clk = ~clk;

  fetch_aligner #(.PARCELS(P), .DEPTH(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .fr_valid(fr_valid), .fr_ready(fr_ready),
    .fr_pc(fr_pc), .fr_parcels(fr_parcels), .fr_fault(fr_fault),
    .redirect(redirect), .out_valid(out_valid), .out_pc(out_pc),
    .out_bits(out_bits), .out_is32(out_is32), .out_fault(out_fault),
    .out_tval(out_tval)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] cpar(input logic [15:0] x);
    return {x[15:2], 2'b01};
  endfunction
  function automatic logic [15:0] wpar(input logic [15:0] x);
    return {x[15:2], 2'b11};
  endfunction

  function automatic ref_t mk(input logic [31:0] pc, input logic [31:0] bits,
                              input logic is32, input logic fault, input logic [31:0] tval);
    ref_t r;
    r.pc = pc; r.bits = bits; r.is32 = is32; r.fault = fault; r.tval = tval;
    return r;
  endfunction

  // model: cut an accepted response into instructions, append them
  task automatic model_take();
    logic [15:0] p [P];
    int idx;
    for (int k = 0; k < P; k++) p[k] = fr_parcels[k*16 +: 16];
    if (fr_fault) begin
      if (m_held) mq.push_back(mk(m_hpc, {16'h0, m_lo}, 1'b1, 1'b1, fr_pc));
      else        mq.push_back(mk(fr_pc, 32'h0, 1'b0, 1'b1, fr_pc));
      m_held = 0;
    end else begin
      idx = 0;
      if (m_held) begin
        mq.push_back(mk(m_hpc, {p[0], m_lo}, 1'b1, 1'b0, 32'h0));
        m_held = 0;
        idx = 1;
      end
      while (idx < P) begin
        if (p[idx][1:0] == 2'b11) begin
          if (idx == P - 1) begin
            m_held = 1; m_lo = p[idx]; m_hpc = fr_pc + 32'(2 * idx);
            idx = idx + 1;
          end else begin
            mq.push_back(mk(fr_pc + 32'(2 * idx), {p[idx+1], p[idx]}, 1'b1, 1'b0, 32'h0));
            idx = idx + 2;
          end
        end else begin
          mq.push_back(mk(fr_pc + 32'(2 * idx), {16'h0, p[idx]}, 1'b0, 1'b0, 32'h0));
          idx = idx + 1;
        end
      end
    end
  endtask

  // one clock: drive, compare against the model, advance the model
  task automatic step(input bit v, input bit flt, input bit redir, input logic [P*16-1:0] pars,
                      input logic [31:0] pc, input string tag, output bit fired);
    bit   exp_ready;
    ref_t e [2];
    bit   ev [2];
    @(posedge clk);
    #1;
    fr_valid = v; fr_fault = flt; redirect = redir; fr_parcels = pars; fr_pc = pc;
    #2;
    exp_ready = !redir && ((mq.size() + P) <= (D + 2));
    check(fr_ready == exp_ready, {tag, "/R9"}, "fr_ready", 32'(fr_ready), 32'(exp_ready));
    fired = v && exp_ready;
    if (fired) model_take();
    if (redir) begin
      mq.delete();
      m_held = 0;
    end
    for (int s = 0; s < 2; s++) begin
      ev[s] = 0;
      if (!redir && mq.size() > 0) begin
        e[s] = mq.pop_front();
        ev[s] = 1;
      end
      check(out_valid[s] == ev[s], {tag, "/R3"}, $sformatf("slot%0d valid", s),
            32'(out_valid[s]), 32'(ev[s]));
      if (ev[s] && out_valid[s]) begin
        check(out_pc[s*32 +: 32] == e[s].pc, {tag, "/R2"}, $sformatf("slot%0d pc", s),
              out_pc[s*32 +: 32], e[s].pc);
        check(out_bits[s*32 +: 32] == e[s].bits && out_is32[s] == e[s].is32, {tag, "/R1"},
              $sformatf("slot%0d bits", s), out_bits[s*32 +: 32], e[s].bits);
        check(out_fault[s] == e[s].fault, tag, $sformatf("slot%0d fault", s),
              32'(out_fault[s]), 32'(e[s].fault));
        if (e[s].fault)
          check(out_tval[s*32 +: 32] == e[s].tval, tag, $sformatf("slot%0d tval", s),
                out_tval[s*32 +: 32], e[s].tval);
      end
    end
  endtask

  task automatic send(input logic [P*16-1:0] pars, input bit flt, input string tag);
    bit f;
    f = 0;
    while (!f) step(1'b1, flt, 1'b0, pars, cur_pc, tag, f);
    cur_pc = cur_pc + 32'(2 * P);
  endtask

  task automatic idle(input int n, input string tag);
    bit f;
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, '0, cur_pc, tag, f);
  endtask

  task automatic jump(input logic [31:0] target, input string tag);
    bit f;
    step(1'b1, 1'b0, 1'b1, {P{cpar(16'h7777)}}, cur_pc, tag, f);
    cur_pc = target;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL R3 watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #2;
    // R10: reset state
    check(out_valid == 2'b00, "R10", "out_valid", 32'(out_valid), 32'h0);
    check(fr_ready == 1'b1, "R10", "fr_ready", 32'(fr_ready), 32'h1);

    // R4/R9: all compressed responses back to back fill the buffer
    for (int i = 0; i < 6; i++)
      send({cpar(16'h10 + 16'(i)), cpar(16'h20), cpar(16'h30), cpar(16'h40 + 16'(i))}, 1'b0, "R4");
    idle(4, "R3");

    // R1: all full-width instructions
    for (int i = 0; i < 3; i++)
      send({16'hA000 + 16'(i), wpar(16'h1110), 16'hB000, wpar(16'h2220 + 16'(i*4))}, 1'b0, "R1");
    idle(3, "R1");

    // R5: straddle across two responses, twice in a row
    send({wpar(16'h5550), cpar(16'h0100), cpar(16'h0200), cpar(16'h0300)}, 1'b0, "R5");
    send({wpar(16'h6660), cpar(16'h0500), wpar(16'h0404), 16'hC0DE}, 1'b0, "R5");
    send({cpar(16'h0900), cpar(16'h0800), cpar(16'h0700), 16'hD00D}, 1'b0, "R5");
    idle(4, "R5");

    // R6: redirect while a half is held; new first parcel is a fresh start
    send({wpar(16'h7770), cpar(16'h0A00), cpar(16'h0B00), cpar(16'h0C00)}, 1'b0, "R6");
    jump(32'h2000, "R6");
    send({cpar(16'h0E00), cpar(16'h0D00), 16'h1234, wpar(16'hABCC)}, 1'b0, "R6");
    idle(3, "R6");

    // R7: fault with nothing held
    send({P{wpar(16'h3330)}}, 1'b1, "R7");
    idle(2, "R7");

    // R8: second half of a straddle faults
    send({wpar(16'h8880), cpar(16'h0F00), cpar(16'h0E10), cpar(16'h0D20)}, 1'b0, "R8");
    send({P{cpar(16'h4440)}}, 1'b1, "R8");
    send({cpar(16'h0110), cpar(16'h0220), cpar(16'h0330), cpar(16'h0440)}, 1'b0, "R8");
    idle(3, "R8");

    // R2: mixed stream with occasional redirects and idles
    for (int i = 0; i < 80; i++) begin
      logic [P*16-1:0] pr;
      int r;
      for (int k = 0; k < P; k++) pr[k*16 +: 16] = 16'($urandom);
      r = int'($urandom % 10);
      if (r == 0) jump({16'h0, 15'($urandom), 1'b0}, "R6");
      else if (r == 1) idle(1, "R2");
      else send(pr, 1'b0, "R2");
    end
    idle(5, "R2");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule